// File: doc/BRIEF.md
# SECDED-Protected OTP Shadow Loader

This controller fills a bank of shadow configuration registers from a one-time-programmable (OTP) array. Each stored word is a 13-bit codeword. It holds 8 data bits, 4 Hamming check bits and one overall parity bit. Every word passes through a single-error-correct, double-error-detect decoder on its way to the bank. A load runs on its own after reset and can be requested again at any later idle time. A load corrects single-bit faults silently. It reports corrected and uncorrectable words through two sticky flags, which stay set until the host clears them.

The same controller performs the one programming operation the array allows. It reads each word of the shadow bank and generates its check and parity bits. It then writes the full codeword into the OTP array, one word per clock. Programming needs the programming-voltage-present input. After programming, a lock stops any further attempt. The array's own fused indication also sets the lock, so the lock still holds after a power cycle. The analog programming path lies outside this block.

Top module: `otp_shadow_ldr`

## Requirements
- R1: After synchronous reset is released, a load starts without a request. In a load, words 0 to NUM_WORDS-1 are written to the bank in ascending order, one per clock. `load_done` pulses for one cycle in the clock after the last write.
- R2: A word with no error reaches the bank unchanged. A load made only of such words sets neither `corr_flag` nor `uncorr_flag`.
- R3: A single flipped bit in any of the 13 codeword bits is corrected before the bank write, and `corr_flag` is set.
- R4: A word whose syndrome shows two flipped bits sets `uncorr_flag` and does not set `corr_flag`. Its data field is written uncorrected.
- R5: `corr_flag`, `uncorr_flag` and `prog_err` are sticky. They stay set through later loads until `flag_clr` is asserted. If a set and a clear happen in the same cycle, the set wins.
- R6: `load_req` in an idle cycle starts a reload. `load_req` and `prog_cmd` have no effect while `busy` is high.
- R7: Codeword layout. Bit 0 is even parity over all 13 bits. Bits 12..1 are Hamming positions 1..12. Check bits sit at positions 1, 2, 4 and 8, and each one makes the XOR of the positions of all set bits equal zero. Data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Data 8'h01 encodes to 13'h000F, and data 8'h80 encodes to 13'h1111.
- R8: `prog_cmd` in an idle cycle, with `vpp_ok` high and no lock, writes the encoded value of every bank word to the OTP array in ascending order, one per clock. It then pulses `prog_done` and sets `locked`. Bank writes and OTP writes never occur in the same cycle.
- R9: `prog_cmd` in an idle, unlocked cycle with `vpp_ok` low writes nothing and sets `prog_err`.
- R10: While `locked` is high, `prog_cmd` writes nothing and leaves `prog_err` unchanged. `locked` is high after a completed programming run, or whenever `otp_fused` is high.
- R11: If `load_req` and `prog_cmd` arrive in the same idle cycle, the load runs and the program command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | Request a reload of the shadow bank |
| prog_cmd | input | 1 | Request the one-time programming run |
| vpp_ok | input | 1 | Programming voltage present |
| otp_fused | input | 1 | Array reports it has already been programmed |
| flag_clr | input | 1 | Clear all sticky status flags |
| otp_addr | output | AW | OTP word address |
| otp_rd_en | output | 1 | OTP read strobe (combinational read data expected) |
| otp_rd_data | input | 13 | OTP codeword read |
| otp_wr_en | output | 1 | OTP write strobe |
| otp_wr_data | output | 13 | OTP codeword to write |
| bank_we | output | 1 | Shadow bank write enable |
| bank_addr | output | AW | Shadow bank address (write and read) |
| bank_wdata | output | 8 | Corrected data to the bank |
| bank_rd_data | input | 8 | Bank data read for programming |
| busy | output | 1 | Controller not idle |
| load_done | output | 1 | One-cycle pulse at load end |
| prog_done | output | 1 | One-cycle pulse at programming end |
| locked | output | 1 | Programming blocked |
| corr_flag | output | 1 | Sticky: a single-bit error was corrected |
| uncorr_flag | output | 1 | Sticky: an uncorrectable word was seen |
| prog_err | output | 1 | Sticky: program rejected for lack of voltage |

## Verification
The hardest cases to reach from the ports are corrupted codewords in the array. In the field these would come from cell disturbance, so the bench edits its own array model between loads instead. It flips one random bit, which may be the parity bit or a check bit, or two chosen data bits in a chosen word. It then requests a reload and compares the bank and both flags against values it works out from its own encoder. The locked state is reached in two ways: through a real programming run, and through a second reset with the fused input high. Program commands are then retried and must produce no array writes.

// File: rtl/otpl_pkg.sv
// Shared widths, types and codeword helper functions for the OTP shadow loader.
// Assumes an 8-bit data word protected by a Hamming(12,8) code plus overall parity.
package otpl_pkg;
    localparam int DW   = 8;               // data bits per word
    localparam int CKW  = 4;               // Hamming check bits
    localparam int HPOS = DW + CKW;        // highest Hamming position
    localparam int CWW  = HPOS + 1;        // stored codeword width (bit 0 = overall parity)

    typedef logic [DW-1:0]  dw_t;
    typedef logic [CWW-1:0] cw_t;
    typedef logic [CKW-1:0] syn_t;

    typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_LOAD, ST_PROG} st_t;

    // True when p is a power of two (a check-bit position).
    function automatic logic is_chk_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Scatter data bits, LSB first, onto the non-check positions; all else zero.
    function automatic cw_t scatter(dw_t d);
        cw_t c = '0;
        int  k = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_chk_pos(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    // Gather the data bits back from the non-check positions.
    function automatic dw_t gather(cw_t c);
        dw_t d = '0;
        int  k = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_chk_pos(p)) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    // XOR of the positions of all set bits in positions 1..HPOS.
    function automatic syn_t syndrome(cw_t c);
        syn_t s = '0;
        for (int p = 1; p <= HPOS; p++) begin
            if (c[p]) s = s ^ p[CKW-1:0];
        end
        return s;
    endfunction
endpackage

// File: rtl/otpl_secded_enc.sv
// Check-bit generator: builds a 13-bit codeword from one data word.
// Assumes the layout in otpl_pkg; purely combinational.
module otpl_secded_enc
    import otpl_pkg::*;
(
    input  dw_t data_i,
    output cw_t cw_o
);
    // Place data, fill check positions from the syndrome, then add parity.
    always_comb begin
        cw_t  c;
        syn_t s;
        c = scatter(data_i);
        s = syndrome(c);
        for (int k = 0; k < CKW; k++) begin
            c[1 << k] = s[k];
        end
        c[0] = ^c[HPOS:1];
        cw_o = c;
    end
endmodule

// File: rtl/otpl_secded_dec.sv
// SECDED decoder: corrects one flipped bit, flags two-bit or invalid patterns.
// Assumes the layout in otpl_pkg; purely combinational. An uncorrectable word
// passes its raw data field through.
module otpl_secded_dec
    import otpl_pkg::*;
(
    input  cw_t  cw_i,
    output dw_t  data_o,
    output logic corr_o,
    output logic uncorr_o
);
    syn_t syn;
    logic par;

    // Syndrome and overall parity of the received word.
    always_comb begin
        syn = syndrome(cw_i);
        par = ^cw_i;
    end

    // Classify the error and flip the located bit when it is correctable.
    always_comb begin
        cw_t fixed;
        fixed    = cw_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (syn != '0 || par) begin
            if (par && (int'(syn) <= HPOS)) begin
                fixed[syn] = ~cw_i[syn];
                corr_o     = 1'b1;
            end else begin
                uncorr_o = 1'b1;
            end
        end
        data_o = gather(fixed);
    end
endmodule

// File: rtl/otp_shadow_ldr.sv
// Top: sequences loads (OTP -> decoder -> shadow bank) and the single
// programming run (bank -> encoder -> OTP). Assumes combinational read data
// on both the OTP and bank read ports, and a synchronous active-low reset.
module otp_shadow_ldr
    import otpl_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_req,
    input  logic           prog_cmd,
    input  logic           vpp_ok,
    input  logic           otp_fused,
    input  logic           flag_clr,
    output logic [AW-1:0]  otp_addr,
    output logic           otp_rd_en,
    input  logic [12:0]    otp_rd_data,
    output logic           otp_wr_en,
    output logic [12:0]    otp_wr_data,
    output logic           bank_we,
    output logic [AW-1:0]  bank_addr,
    output logic [7:0]     bank_wdata,
    input  logic [7:0]     bank_rd_data,
    output logic           busy,
    output logic           load_done,
    output logic           prog_done,
    output logic           locked,
    output logic           corr_flag,
    output logic           uncorr_flag,
    output logic           prog_err
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_WORDS - 1);

    st_t           st;
    logic [AW-1:0] idx;
    logic          lock_q;
    logic          dec_corr, dec_uncorr;
    dw_t           dec_data;
    cw_t           enc_cw;
    logic          at_last;
    logic          idle_go_load, idle_go_prog, perr_set;

    // Decoder on the read path (R3, R4) and encoder on the write path (R7).
    otpl_secded_dec u_dec (
        .cw_i     (otp_rd_data),
        .data_o   (dec_data),
        .corr_o   (dec_corr),
        .uncorr_o (dec_uncorr)
    );

    otpl_secded_enc u_enc (
        .data_i (bank_rd_data),
        .cw_o   (enc_cw)
    );

    // Idle-state command decode: load wins over program (R11), lock gates program (R10).
    always_comb begin
        at_last      = (idx == LAST_IDX);
        locked       = lock_q | otp_fused;
        idle_go_load = (st == ST_IDLE) && load_req;
        idle_go_prog = (st == ST_IDLE) && !load_req && prog_cmd && !locked && vpp_ok;
        perr_set     = (st == ST_IDLE) && !load_req && prog_cmd && !locked && !vpp_ok;
    end

    // Sequencer: boot load, reloads and the programming walk (R1, R6, R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_BOOT;
            idx       <= '0;
            load_done <= 1'b0;
            prog_done <= 1'b0;
            lock_q    <= 1'b0;
        end else begin
            load_done <= 1'b0;
            prog_done <= 1'b0;
            unique case (st)
                ST_BOOT: begin
                    st  <= ST_LOAD;
                    idx <= '0;
                end
                ST_IDLE: begin
                    if (idle_go_load) begin
                        st  <= ST_LOAD;
                        idx <= '0;
                    end else if (idle_go_prog) begin
                        st  <= ST_PROG;
                        idx <= '0;
                    end
                end
                ST_LOAD: begin
                    idx <= idx + 1'b1;
                    if (at_last) begin
                        st        <= ST_IDLE;
                        load_done <= 1'b1;
                    end
                end
                ST_PROG: begin
                    idx <= idx + 1'b1;
                    if (at_last) begin
                        st        <= ST_IDLE;
                        prog_done <= 1'b1;
                        lock_q    <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Sticky status flags; a set in the same cycle as a clear wins (R5).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_flag   <= 1'b0;
            uncorr_flag <= 1'b0;
            prog_err    <= 1'b0;
        end else begin
            corr_flag   <= (corr_flag   & ~flag_clr) | ((st == ST_LOAD) & dec_corr);
            uncorr_flag <= (uncorr_flag & ~flag_clr) | ((st == ST_LOAD) & dec_uncorr);
            prog_err    <= (prog_err    & ~flag_clr) | perr_set;
        end
    end

    // Array and bank port drive from the current state and index.
    always_comb begin
        otp_addr    = idx;
        bank_addr   = idx;
        otp_rd_en   = (st == ST_LOAD);
        bank_we     = (st == ST_LOAD);
        bank_wdata  = dec_data;
        otp_wr_en   = (st == ST_PROG);
        otp_wr_data = enc_cw;
        busy        = (st != ST_IDLE);
    end
endmodule

// File: rtl/otpl_chk.sv
// Assertion checker for otp_shadow_ldr, attached by bind below.
module otpl_chk #(
    parameter int NUM_WORDS = 8,
    localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_req,
    input logic          prog_cmd,
    input logic          vpp_ok,
    input logic          flag_clr,
    input logic          otp_wr_en,
    input logic          bank_we,
    input logic [AW-1:0] bank_addr,
    input logic          busy,
    input logic          load_done,
    input logic          locked,
    input logic          corr_flag,
    input logic          uncorr_flag,
    input logic          prog_err
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_WORDS - 1);

    // R8: the bank and the array are never written together.
    p_we_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_we && otp_wr_en));

    // R1: consecutive bank writes step the address by one.
    p_addr_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && $past(bank_we)) |-> (bank_addr == AW'($past(bank_addr) + 1'b1)));

    // R1: the done pulse follows the write of the last word.
    p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> ($past(bank_we) && $past(bank_addr) == LAST_IDX));

    // R10: a programming run never starts while locked.
    p_no_prog_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otp_wr_en) |-> $past(!locked));

    // R5: error flags hold until cleared.
    p_corr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(corr_flag) && !$past(flag_clr)) |-> corr_flag);
    p_uncorr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uncorr_flag) && !$past(flag_clr)) |-> uncorr_flag);

    // R2: error flags only rise after a bank write.
    p_flag_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(corr_flag) || $rose(uncorr_flag)) |-> $past(bank_we));

    // R9: an idle unlocked program command without voltage raises the error flag.
    p_prog_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_cmd && !vpp_ok && !busy && !locked && !load_req) |-> prog_err);
endmodule

bind otp_shadow_ldr otpl_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_req    (load_req),
    .prog_cmd    (prog_cmd),
    .vpp_ok      (vpp_ok),
    .flag_clr    (flag_clr),
    .otp_wr_en   (otp_wr_en),
    .bank_we     (bank_we),
    .bank_addr   (bank_addr),
    .busy        (busy),
    .load_done   (load_done),
    .locked      (locked),
    .corr_flag   (corr_flag),
    .uncorr_flag (uncorr_flag),
    .prog_err    (prog_err)
);

// File: tb/otp_shadow_ldr_tb.sv
// Self-checking bench: array and bank models, random error injection, directed corners.
module otp_shadow_ldr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n, load_req, prog_cmd, vpp_ok, otp_fused, flag_clr;
    logic [AW-1:0] otp_addr, bank_addr;
    logic otp_rd_en, otp_wr_en, bank_we, busy, load_done, prog_done, locked;
    logic corr_flag, uncorr_flag, prog_err;
    logic [12:0] otp_rd_data, otp_wr_data;
    logic [7:0]  bank_wdata, bank_rd_data;

    logic [12:0] otp_mem [NW];
    logic [7:0]  bank_mem[NW];
    logic [7:0]  gold    [NW];

    int checks = 0;
    int fails  = 0;
    int bank_wr_cnt, order_bad, otp_wr_cnt, otp_bad;
    logic prev_last, done_after_last;

    otp_shadow_ldr #(.NUM_WORDS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .prog_cmd(prog_cmd),
        .vpp_ok(vpp_ok), .otp_fused(otp_fused), .flag_clr(flag_clr),
        .otp_addr(otp_addr), .otp_rd_en(otp_rd_en), .otp_rd_data(otp_rd_data),
        .otp_wr_en(otp_wr_en), .otp_wr_data(otp_wr_data),
        .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
        .bank_rd_data(bank_rd_data), .busy(busy), .load_done(load_done),
        .prog_done(prog_done), .locked(locked), .corr_flag(corr_flag),
        .uncorr_flag(uncorr_flag), .prog_err(prog_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign otp_rd_data  = otp_mem[otp_addr];
    assign bank_rd_data = bank_mem[bank_addr];

    // Position of data bit k in the codeword (R7: 3,5,6,7,9,10,11,12).
    function automatic int dpos(int k);
        int tbl[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return tbl[k];
    endfunction

    // Reference encoder: check bits equal the XOR of the data positions.
    function automatic logic [12:0] ref_enc(logic [7:0] d);
        logic [12:0] c = '0;
        logic [3:0]  s = '0;
        for (int k = 0; k < 8; k++) begin
            if (d[k]) begin
                c[dpos(k)] = 1'b1;
                s = s ^ 4'(dpos(k));
            end
        end
        c[1] = s[0]; c[2] = s[1]; c[4] = s[2]; c[8] = s[3];
        c[0] = ^c[12:1];
        return c;
    endfunction

    // Array and bank models.
    always @(posedge clk) begin
        if (bank_we)   bank_mem[bank_addr] <= bank_wdata;
        if (otp_wr_en) otp_mem[otp_addr]   <= otp_wr_data;
    end

    // Write monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (load_done) done_after_last = prev_last;
        prev_last = bank_we && (bank_addr == AW'(NW - 1));
        if (bank_we) begin
            if (int'(bank_addr) != bank_wr_cnt) order_bad++;
            bank_wr_cnt++;
        end
        if (otp_wr_en) begin
            otp_wr_cnt++;
            if (otp_wr_data != ref_enc(bank_mem[otp_addr])) otp_bad++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        bank_wr_cnt = 0; order_bad = 0; otp_wr_cnt = 0; otp_bad = 0;
        done_after_last = 1'b0;
    endtask

    // Fill the array with clean codewords for fresh random data.
    task automatic fill_clean();
        for (int w = 0; w < NW; w++) begin
            gold[w]    = 8'($urandom);
            otp_mem[w] = ref_enc(gold[w]);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) load_req = 1'b1;
        if (which == 1) prog_cmd = 1'b1;
        if (which == 2) flag_clr = 1'b1;
        if (which == 3) begin load_req = 1'b1; prog_cmd = 1'b1; end
        @(negedge clk);
        load_req = 1'b0; prog_cmd = 1'b0; flag_clr = 1'b0;
    endtask

    // Wait for the load-done pulse and check the write sequence (R1).
    task automatic wait_load(input string tag);
        int n = 0;
        while (n < 100) begin
            if (load_done) break;
            @(negedge clk);
            n++;
        end
        #1;
        check({tag, " R1 done seen"}, int'(load_done), 1);
        check({tag, " R1 write count"}, bank_wr_cnt, NW);
        check({tag, " R1 write order"}, order_bad, 0);
        check({tag, " R1 done after last"}, int'(done_after_last), 1);
    endtask

    task automatic wait_prog();
        int n = 0;
        while (n < 100) begin
            if (prog_done) break;
            @(negedge clk);
            n++;
        end
        #1;
        check("R8 prog_done seen", int'(prog_done), 1);
    endtask

    task automatic cmp_bank(input string tag, input int w_alt, input logic [7:0] alt);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int w = 0; w < NW; w++) begin
            logic [7:0] e = (w == w_alt) ? alt : gold[w];
            if (bank_mem[w] != e && bad == 0) begin
                first_act = int'(bank_mem[w]); first_exp = int'(e);
            end
            if (bank_mem[w] != e) bad++;
        end
        check({tag, " bank word"}, first_act, first_exp);
        check({tag, " bank mismatches"}, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        rst_n = 1'b0; load_req = 1'b0; prog_cmd = 1'b0; vpp_ok = 1'b0;
        otp_fused = 1'b0; flag_clr = 1'b0;
        for (int w = 0; w < NW; w++) bank_mem[w] = 8'h00;
        fill_clean();
        clear_mon();
        repeat (3) @(negedge clk);
        // Reset state
        check("R1 reset load_done", int'(load_done), 0);
        check("R5 reset corr_flag", int'(corr_flag), 0);
        check("R5 reset uncorr_flag", int'(uncorr_flag), 0);
        check("R10 reset locked", int'(locked), 0);
        clear_mon();
        rst_n = 1'b1;
        // R1: boot load without request; R2: clean words, no flags
        wait_load("boot");
        cmp_bank("R2 boot", -1, 8'h00);
        check("R2 clean corr_flag", int'(corr_flag), 0);
        check("R2 clean uncorr_flag", int'(uncorr_flag), 0);

        // R3: random single-bit faults, including parity and check bits
        for (int r = 0; r < 8; r++) begin
            int w, b;
            fill_clean();
            w = (r == 0) ? 0 : (r == 1) ? NW - 1 : int'($urandom_range(NW - 1, 0));
            b = (r == 0) ? 0 : (r == 1) ? 12 : int'($urandom_range(12, 0));
            otp_mem[w][b] = ~otp_mem[w][b];
            clear_mon();
            pulse(0);
            wait_load("R3 reload");
            cmp_bank("R3 corrected", -1, 8'h00);
            check("R3 corr_flag", int'(corr_flag), 1);
            check("R3 uncorr_flag", int'(uncorr_flag), 0);
            pulse(2);
            check("R5 corr cleared", int'(corr_flag), 0);
        end

        // R4: two data bits flipped in one word
        begin
            int w = 3;
            fill_clean();
            otp_mem[w] = otp_mem[w] ^ (13'd1 << dpos(1)) ^ (13'd1 << dpos(6));
            clear_mon();
            pulse(0);
            wait_load("R4 reload");
            cmp_bank("R4 raw data", w, gold[w] ^ 8'h42);
            check("R4 uncorr_flag", int'(uncorr_flag), 1);
            check("R4 corr_flag", int'(corr_flag), 0);
        end
        // R5: clean load keeps the sticky flag; clear drops it
        fill_clean();
        clear_mon();
        pulse(0);
        wait_load("R5 reload");
        check("R5 uncorr sticky", int'(uncorr_flag), 1);
        pulse(2);
        check("R5 uncorr cleared", int'(uncorr_flag), 0);

        // R6: requests while busy are ignored
        fill_clean();
        clear_mon();
        vpp_ok = 1'b1;
        pulse(0);
        repeat (2) @(negedge clk);
        pulse(0);
        pulse(1);
        wait_load("R6 busy");
        repeat (5) @(negedge clk);
        check("R6 no extra bank writes", bank_wr_cnt, NW);
        check("R6 no otp writes", otp_wr_cnt, 0);
        check("R6 idle again", int'(busy), 0);

        // R11: simultaneous load and program, load wins
        clear_mon();
        pulse(3);
        wait_load("R11 tie");
        repeat (3) @(negedge clk);
        check("R11 no otp writes", otp_wr_cnt, 0);
        check("R11 not locked", int'(locked), 0);

        // R9: program without voltage
        vpp_ok = 1'b0;
        clear_mon();
        pulse(1);
        repeat (3) @(negedge clk);
        check("R9 prog_err", int'(prog_err), 1);
        check("R9 no otp writes", otp_wr_cnt, 0);
        check("R9 not locked", int'(locked), 0);
        pulse(2);
        check("R5 prog_err cleared", int'(prog_err), 0);

        // R8/R7: program from bank contents
        for (int w = 0; w < NW; w++) begin
            gold[w] = 8'($urandom);
        end
        gold[0] = 8'h01;
        gold[1] = 8'h80;
        for (int w = 0; w < NW; w++) bank_mem[w] = gold[w];
        for (int w = 0; w < NW; w++) otp_mem[w] = 13'h0;
        vpp_ok = 1'b1;
        clear_mon();
        pulse(1);
        wait_prog();
        check("R8 otp write count", otp_wr_cnt, NW);
        check("R8 encoded words", otp_bad, 0);
        check("R8 locked", int'(locked), 1);
        check("R7 encode 01", int'(otp_mem[0]), 32'h000F);
        check("R7 encode 80", int'(otp_mem[1]), 32'h1111);
        // Round trip: reload from the programmed array
        for (int w = 0; w < NW; w++) bank_mem[w] = 8'h00;
        clear_mon();
        pulse(0);
        wait_load("R8 round trip");
        cmp_bank("R8 round trip", -1, 8'h00);
        check("R8 no flags", int'(corr_flag | uncorr_flag), 0);

        // R10: second program attempt is blocked
        clear_mon();
        pulse(1);
        repeat (4) @(negedge clk);
        check("R10 no otp writes", otp_wr_cnt, 0);
        check("R10 no prog_err", int'(prog_err), 0);

        // R10: fused array locks from reset
        rst_n = 1'b0;
        otp_fused = 1'b1;
        repeat (3) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
        wait_load("R10 fused boot");
        check("R10 fused locked", int'(locked), 1);
        clear_mon();
        pulse(1);
        repeat (4) @(negedge clk);
        check("R10 fused no otp writes", otp_wr_cnt, 0);
        check("R10 fused no prog_err", int'(prog_err), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule